// File: doc/BRIEF.md
# PCI Master Bus Parking and Grant Handler

This block sits on the bus-master side of a PCI interface. It watches the grant line and the shared bus activity signals. From these it decides when to drive the shared address/data, command/byte-enable and parity lines to a parked value, and when to launch the address phase of a transaction the rest of the chip has asked for. Pulling those lines to known levels while the bus is idle keeps them from floating. The staggered enable keeps parity one clock behind the lines it covers, which matches how the bus checks parity.

The same logic serves a central arbiter that sits on the same chip and one that sits elsewhere, because it only sees a request output and a grant input. A transaction can start from the idle state after the block's request has been granted. It can also start directly from the parked state. The block handles only the address phase. When that clock ends it hands the bus back through a one-clock turnaround, and logic elsewhere takes over the data phases. Every output is registered, and each input takes effect after the rising edge that samples it.

Top module: `pci_park_master`

## Requirements
- R1: Parking starts only when a rising edge samples grant low, the block's own request deasserted, no transaction wanted, and both FRAME# and IRDY# high (bus idle). After that edge the AD and C/BE# enables are high and both buses carry all zeros.
- R2: While parked, the PAR enable rises one clock after the AD/C/BE# enables. In every clock, par_out equals the XOR of all ad_out and cbe_out bits of the previous clock (even parity).
- R3: When a rising edge samples the grant high, every output enable (AD, C/BE#, PAR, FRAME#) is low after that edge.
- R4: When the block is parked and a transaction is wanted at an edge that also samples the grant low and the bus idle, FRAME# is driven low after that edge, with the address on AD and the command on C/BE#.
- R5: req_n goes low after an edge that samples the transaction request high, except when the block is in its address phase or entering it. req_n is high in the clock in which FRAME# is low.
- R6: If req_n is low and an edge in the non-parked idle state samples the grant low with the bus idle, FRAME# is driven low after that edge (one clock after the grant is seen).
- R7: FRAME# is low for exactly one clock. It is followed by one clock with all enables low before the block can park or start again.
- R8: If an edge samples the bus busy (FRAME# or IRDY# low) while the block is parked, all enables are low after that edge.
- R9: During and right after reset, all enables are low, req_n is high, frame_out_n is high and par_out is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset |
| gnt_n | input | 1 | Grant from the arbiter, active low |
| frame_in_n | input | 1 | Sampled FRAME# of the shared bus |
| irdy_in_n | input | 1 | Sampled IRDY# of the shared bus |
| xfer_req | input | 1 | Internal request to start a transaction, held until FRAME# is driven |
| xfer_addr | input | AD_W | Address for the address phase |
| xfer_cmd | input | CBE_W | Bus command for the address phase |
| req_n | output | 1 | Request to the arbiter, active low |
| frame_out_n | output | 1 | FRAME# value driven by this block |
| frame_oe | output | 1 | FRAME# output enable |
| ad_out | output | AD_W | AD value |
| ad_oe | output | 1 | AD output enable |
| cbe_out | output | CBE_W | C/BE# value |
| cbe_oe | output | 1 | C/BE# output enable |
| par_out | output | 1 | PAR value |
| par_oe | output | 1 | PAR output enable |

## Verification
The bench builds the block with its default widths, a 32-bit AD bus and a 4-bit C/BE# bus. Parity therefore covers 36 bits, and random addresses give both odd and even bit counts for the parity that follows an address phase. With these widths, random grant loss during every state, bus activity seen while parked, and starts both from the parked state and from a granted request can all be reached within a few thousand clocks.

// File: rtl/park_pkg.sv
package park_pkg;

    typedef enum logic [2:0] {
        ST_IDLE      = 3'd0,
        ST_PARK_AD   = 3'd1,
        ST_PARK_FULL = 3'd2,
        ST_ADDR      = 3'd3,
        ST_RELEASE   = 3'd4
    } park_state_e;

    typedef struct packed {
        park_state_e st;
        logic        ad_oe;
        logic        par_oe;
        logic        frame_oe;
    } fsm_regs_t;

endpackage

// File: rtl/park_fsm.sv
module park_fsm
    import park_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        gnt,
    input  logic        bus_idle,
    input  logic        want,
    input  logic        req_on,
    input  logic        frame_in_n,
    input  logic        irdy_in_n,
    output park_state_e state_q_o,
    output logic        start_o,
    output logic        ad_oe_o,
    output logic        par_oe_o,
    output logic        frame_oe_o
);

    fsm_regs_t r_q, r_d;

    always_comb begin
        r_d    = r_q;
        r_d.st = r_q.st;
        unique case (r_q.st)
            ST_IDLE: begin
                if (gnt && bus_idle) begin
                    if (req_on)     r_d.st = ST_ADDR;
                    else if (!want) r_d.st = ST_PARK_AD;
                end
            end
            ST_PARK_AD, ST_PARK_FULL: begin
                if (!gnt || !bus_idle) r_d.st = ST_RELEASE;
                else if (want)         r_d.st = ST_ADDR;
                else                   r_d.st = ST_PARK_FULL;
            end
            ST_ADDR:    r_d.st = ST_RELEASE;
            ST_RELEASE: r_d.st = ST_IDLE;
            default:    r_d.st = ST_IDLE;
        endcase
        r_d.ad_oe    = (r_d.st == ST_PARK_AD) || (r_d.st == ST_PARK_FULL) ||
                       (r_d.st == ST_ADDR);
        r_d.par_oe   = (r_d.st == ST_PARK_FULL);
        r_d.frame_oe = (r_d.st == ST_ADDR);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, ad_oe: 1'b0, par_oe: 1'b0, frame_oe: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign state_q_o  = r_q.st;
    assign start_o    = (r_d.st == ST_ADDR);
    assign ad_oe_o    = r_q.ad_oe;
    assign par_oe_o   = r_q.par_oe;
    assign frame_oe_o = r_q.frame_oe;

    // R3: grant seen high, every enable drops after that edge
    a_r3_release_on_gnt_loss: assert property (@(posedge clk) disable iff (!rst_n)
        !gnt |=> (!r_q.ad_oe && !r_q.par_oe && !r_q.frame_oe));

    // R2: PAR enable only rises after AD enable was already on
    a_r2_par_after_ad: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(r_q.par_oe) |-> $past(r_q.ad_oe));

    // R7: FRAME# enable never lasts two clocks, then a turnaround clock
    a_r7_frame_single: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.frame_oe |=> (!r_q.frame_oe && !r_q.ad_oe && !r_q.par_oe));

    // R8: busy bus while parked drops drive
    a_r8_busy_release: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.ad_oe && !r_q.frame_oe && (!frame_in_n || !irdy_in_n)) |=> !r_q.ad_oe);

endmodule

// File: rtl/park_req.sv
module park_req (
    input  logic clk,
    input  logic rst_n,
    input  logic want,
    input  logic start,
    input  logic in_addr,
    input  logic frame_oe,
    output logic req_on_o
);

    logic req_q, req_d;

    always_comb begin
        req_d = want && !start && !in_addr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) req_q <= 1'b0;
        else        req_q <= req_d;
    end

    assign req_on_o = req_q;

    // R5: request released in the clock FRAME# is driven
    a_r5_req_off_with_frame: assert property (@(posedge clk) disable iff (!rst_n)
        frame_oe |-> !req_q);

endmodule

// File: rtl/park_parity.sv
module park_parity #(
    parameter int unsigned W = 36
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] bits_q,
    output logic         par_o
);

    logic par_q, par_d;

    always_comb begin
        par_d = ^bits_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) par_q <= 1'b0;
        else        par_q <= par_d;
    end

    assign par_o = par_q;

    // R2: parity tracks the previous clock's AD/C-BE bits
    a_r2_parity_prev: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (par_q == ^$past(bits_q)));

endmodule

// File: rtl/pci_park_master.sv
module pci_park_master
    import park_pkg::*;
#(
    parameter int unsigned AD_W  = 32,
    parameter int unsigned CBE_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             gnt_n,
    input  logic             frame_in_n,
    input  logic             irdy_in_n,
    input  logic             xfer_req,
    input  logic [AD_W-1:0]  xfer_addr,
    input  logic [CBE_W-1:0] xfer_cmd,
    output logic             req_n,
    output logic             frame_out_n,
    output logic             frame_oe,
    output logic [AD_W-1:0]  ad_out,
    output logic             ad_oe,
    output logic [CBE_W-1:0] cbe_out,
    output logic             cbe_oe,
    output logic             par_out,
    output logic             par_oe
);

    localparam int unsigned PW = AD_W + CBE_W;

    typedef struct packed {
        logic [AD_W-1:0]  ad;
        logic [CBE_W-1:0] cbe;
    } bus_vals_t;

    logic        gnt, bus_idle, req_on, start;
    park_state_e st_q;
    logic        ad_oe_w, par_oe_w, frame_oe_w;
    bus_vals_t   v_q, v_d;

    assign gnt      = !gnt_n;
    assign bus_idle = frame_in_n && irdy_in_n;

    park_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .gnt        (gnt),
        .bus_idle   (bus_idle),
        .want       (xfer_req),
        .req_on     (req_on),
        .frame_in_n (frame_in_n),
        .irdy_in_n  (irdy_in_n),
        .state_q_o  (st_q),
        .start_o    (start),
        .ad_oe_o    (ad_oe_w),
        .par_oe_o   (par_oe_w),
        .frame_oe_o (frame_oe_w)
    );

    park_req u_req (
        .clk      (clk),
        .rst_n    (rst_n),
        .want     (xfer_req),
        .start    (start),
        .in_addr  (st_q == ST_ADDR),
        .frame_oe (frame_oe_w),
        .req_on_o (req_on)
    );

    always_comb begin
        v_d = '0;
        if (start) begin
            v_d.ad  = xfer_addr;
            v_d.cbe = xfer_cmd;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) v_q <= '0;
        else        v_q <= v_d;
    end

    park_parity #(.W(PW)) u_par (
        .clk    (clk),
        .rst_n  (rst_n),
        .bits_q ({v_q.ad, v_q.cbe}),
        .par_o  (par_out)
    );

    assign req_n       = !req_on;
    assign frame_oe    = frame_oe_w;
    assign frame_out_n = !frame_oe_w;
    assign ad_out      = v_q.ad;
    assign cbe_out     = v_q.cbe;
    assign ad_oe       = ad_oe_w;
    assign cbe_oe      = ad_oe_w;
    assign par_oe      = par_oe_w;

    // R1: drive without FRAME# only after a sampled grant
    a_r1_park_needs_grant: assert property (@(posedge clk) disable iff (!rst_n)
        (ad_oe && !frame_oe) |-> $past(gnt));

    // R1: parked values are zero
    a_r1_park_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (ad_oe && !frame_oe) |-> (ad_out == '0 && cbe_out == '0));

endmodule

// File: tb/pci_park_master_bench.sv
module pci_park_master_bench;

    localparam int AW = 32;
    localparam int CW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          gnt_n = 1'b1, frame_in_n = 1'b1, irdy_in_n = 1'b1, xfer_req = 1'b0;
    logic [AW-1:0] xfer_addr = '0;
    logic [CW-1:0] xfer_cmd = '0;
    logic          req_n, frame_out_n, frame_oe, ad_oe, cbe_oe, par_out, par_oe;
    logic [AW-1:0] ad_out;
    logic [CW-1:0] cbe_out;

    int checks = 0, failures = 0;
    bit done = 1'b0;

    // model state: 0 idle, 1 park-ad, 2 park-full, 3 addr, 4 release
    int            m_st;
    bit            m_req, m_par;
    logic [AW-1:0] m_ad;
    logic [CW-1:0] m_cbe;

    always #5 clk = ~clk;

    pci_park_master u_pci_park_master (
        .clk(clk), .rst_n(rst_n), .gnt_n(gnt_n), .frame_in_n(frame_in_n),
        .irdy_in_n(irdy_in_n), .xfer_req(xfer_req), .xfer_addr(xfer_addr),
        .xfer_cmd(xfer_cmd), .req_n(req_n), .frame_out_n(frame_out_n),
        .frame_oe(frame_oe), .ad_out(ad_out), .ad_oe(ad_oe), .cbe_out(cbe_out),
        .cbe_oe(cbe_oe), .par_out(par_out), .par_oe(par_oe)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int next_state(int st, bit g, bit idl, bit want, bit rq);
        case (st)
            0: return (g && idl) ? (rq ? 3 : (!want ? 1 : 0)) : 0;
            1, 2: return (!g || !idl) ? 4 : (want ? 3 : 2);
            3: return 4;
            default: return 0;
        endcase
    endfunction

    function automatic bit odd_bits(logic [AW-1:0] a, logic [CW-1:0] c);
        bit p = 1'b0;
        for (int i = 0; i < AW; i++) p ^= a[i];
        for (int i = 0; i < CW; i++) p ^= c[i];
        return p;
    endfunction

    // Drive inputs at a falling edge, advance model, compare at next falling edge
    task automatic step(input bit gn, input bit fr, input bit ir, input bit xr,
                        input logic [AW-1:0] a, input logic [CW-1:0] c);
        int ns;
        gnt_n = gn; frame_in_n = fr; irdy_in_n = ir; xfer_req = xr;
        xfer_addr = a; xfer_cmd = c;
        ns    = next_state(m_st, !gn, fr && ir, xr, m_req);
        m_par = odd_bits(m_ad, m_cbe);
        m_req = xr && (ns != 3) && (m_st != 3);
        m_ad  = (ns == 3) ? a : '0;
        m_cbe = (ns == 3) ? c : '0;
        m_st  = ns;
        @(negedge clk);
        chk("R1 ad_oe",  ad_oe,  (m_st == 1 || m_st == 2 || m_st == 3));
        chk("R1 cbe_oe", cbe_oe, (m_st == 1 || m_st == 2 || m_st == 3));
        chk("R1 ad/cbe", {ad_out, cbe_out}, {m_ad, m_cbe});
        chk("R2 par_oe", par_oe, (m_st == 2));
        chk("R2 par_out", par_out, m_par);
        chk("R4 frame_oe", frame_oe, (m_st == 3));
        chk("R4 frame_out_n", frame_out_n, !(m_st == 3));
        chk("R5 req_n", req_n, !m_req);
    endtask

    initial begin
        #200000;
        checks++; failures++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        m_st = 0; m_req = 0; m_par = 0; m_ad = '0; m_cbe = '0;
        repeat (3) @(negedge clk);
        // R9: reset state
        chk("R9 ad_oe", ad_oe, 0);
        chk("R9 par_oe", par_oe, 0);
        chk("R9 frame_out_n", frame_out_n, 1);
        chk("R9 req_n", req_n, 1);
        chk("R9 par_out", par_out, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R9 after reset frame_oe", frame_oe, 0);

        // R1/R2: grant with idle bus -> park, PAR one clock later
        step(0, 1, 1, 0, '0, '0);
        chk("R1 park entry ad_oe", ad_oe, 1);
        chk("R2 par not yet", par_oe, 0);
        step(0, 1, 1, 0, '0, '0);
        chk("R2 par staggered", par_oe, 1);
        // R4: start from parked state
        step(0, 1, 1, 1, 32'h0000_0007, 4'h6);
        chk("R4 frame from park", frame_out_n, 0);
        chk("R5 req high with frame", req_n, 1);
        step(0, 1, 1, 0, '0, '0);
        chk("R7 turnaround", {frame_oe, ad_oe, par_oe}, 3'b000);
        chk("R2 parity of address (odd count)", par_out, 1);
        // R3: grant lost while parked
        step(0, 1, 1, 0, '0, '0);
        step(0, 1, 1, 0, '0, '0);
        step(0, 1, 1, 0, '0, '0);
        step(1, 1, 1, 0, '0, '0);
        chk("R3 release on grant loss", {ad_oe, cbe_oe, par_oe}, 3'b000);
        // R8: busy bus while parked
        step(0, 1, 1, 0, '0, '0);
        step(0, 1, 1, 0, '0, '0);
        step(0, 1, 1, 0, '0, '0);
        step(0, 0, 1, 0, '0, '0);
        chk("R8 busy release", ad_oe, 0);
        // R5/R6: request first, grant later
        step(1, 1, 1, 1, 32'h1234_5678, 4'h7);
        step(1, 1, 1, 1, 32'h1234_5678, 4'h7);
        chk("R5 req asserted", req_n, 0);
        step(0, 1, 1, 1, 32'h1234_5678, 4'h7);
        chk("R6 frame after grant", frame_out_n, 0);
        chk("R6 address value", ad_out, 32'h1234_5678);
        step(1, 1, 1, 0, '0, '0);
        step(1, 1, 1, 0, '0, '0);

        // random mix
        for (int i = 0; i < 4000; i++) begin
            bit gn = ($urandom_range(0, 3) == 0);
            bit fr = ($urandom_range(0, 7) != 0);
            bit ir = ($urandom_range(0, 7) != 0);
            bit xr = ($urandom_range(0, 4) == 0) ? ~xfer_req : xfer_req;
            step(gn, fr, ir, xr, 32'($urandom), 4'($urandom));
        end

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule